// File: doc/BRIEF.md
# Pending Interrupt Queue

This block keeps track of interrupts that outside sources have raised and that the processor has not yet finished handling. Each interrupt is only a 16-bit identifier. Any data that goes with the event is placed in shared memory by the source, so the queue stores only the identifier. A raise request appends the identifier at the tail. The request is dropped if that identifier is already waiting, or if every slot is taken. A dropped request caused by a full queue is reported with a one-cycle overflow pulse.

The oldest entry is always shown as a valid and identifier pair. The processor looks at the queue only between instructions, when it drives `at_boundary`, and the offer output is qualified by that input. Offering an entry does not remove it. An entry leaves the queue only when an acknowledge names its identifier, so it stays pending while its handler runs. An acknowledge can free any slot, and the entries that remain keep their arrival order. If an acknowledge and a raise arrive in the same cycle, the acknowledge is applied first.

Top module: `pend_irq_queue`

## Requirements
- R1: While reset is low, and in the first cycle after it, `head_vld`, `offer_vld` and `overflow` are 0 and the queue holds no entries.
- R2: A raise request whose identifier is not pending, made while a slot is free, appends that identifier at the tail. From the next clock edge, entries reach the head in the order they arrived.
- R3: A raise request whose identifier is already pending is dropped. It does not raise `overflow`, and the queue contents do not change.
- R4: A raise request of a new identifier while all DEPTH slots (8 by default) are in use is dropped. `overflow` is then 1 for exactly the cycle after that clock edge.
- R5: An acknowledge that names a pending identifier removes that entry, whatever its position. The remaining entries keep their relative order.
- R6: An acknowledge that names an identifier that is not pending leaves the queue unchanged.
- R7: When an acknowledge and a raise arrive in the same cycle, the acknowledge is applied first. A raise on a full queue is therefore accepted if the same cycle frees a slot. A raise of the identifier being acknowledged is appended again at the tail.
- R8: While the head entry is not acknowledged, `head_vld` stays 1 and `head_id` stays unchanged, even when other entries are raised or removed.
- R9: `offer_vld` is 1 exactly when an entry is pending and `at_boundary` is 1. `head_vld` does not depend on `at_boundary`.
- R10: An entry that is offered stays at the head, and stays offered, on every cycle until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Raise request strobe |
| raise_id | input | ID_W | Identifier to raise |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Identifier whose handling is complete |
| at_boundary | input | 1 | Processor is between instructions |
| head_vld | output | 1 | At least one entry is pending |
| head_id | output | ID_W | Identifier of the oldest pending entry |
| offer_vld | output | 1 | Head entry offered to the processor |
| overflow | output | 1 | One-cycle pulse after a raise dropped because the queue was full |

## Verification
Directed sequences check each of the following on its own:
- plain arrival order;
- duplicate raises;
- acknowledges of identifiers that are not pending;
- raising into a full queue;
- same-cycle acknowledge and raise, both on a full queue and with the same identifier.

These separate a queue that drops duplicates from one that only checks fullness. They also separate acknowledge-first ordering from raise-first ordering.

A near-exhaustive sweep fills the queue and then removes each of the eight slot positions in turn, draining after each removal. This shows whether compaction keeps the order of the survivors at every position.

A long pseudo-random run then draws identifiers from a set of twelve. This keeps the queue near full and makes duplicates and stale acknowledges common. The head, offer and overflow outputs are compared every cycle against a model of the queue kept in the bench.

// File: rtl/pend_irq_queue.sv
module pend_irq_queue #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raise_vld,
  input  logic [ID_W-1:0] raise_id,
  input  logic            ack_vld,
  input  logic [ID_W-1:0] ack_id,
  input  logic            at_boundary,
  output logic            head_vld,
  output logic [ID_W-1:0] head_id,
  output logic            offer_vld,
  output logic            overflow
);

  logic [ID_W-1:0]  slot_q [DEPTH];
  logic [DEPTH-1:0] live_q;

  logic [ID_W-1:0]  kept_id [DEPTH];
  logic [DEPTH-1:0] kept_live;
  logic [ID_W-1:0]  nxt_id  [DEPTH];
  logic [DEPTH-1:0] nxt_live;
  logic             dup, full, take;

  always_comb begin
    logic shifted;
    shifted = 1'b0;
    dup     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      shifted = shifted | (ack_vld & live_q[i] & (slot_q[i] == ack_id));
      if (!shifted) begin
        kept_id[i]   = slot_q[i];
        kept_live[i] = live_q[i];
      end else if (i == DEPTH - 1) begin
        kept_id[i]   = '0;
        kept_live[i] = 1'b0;
      end else begin
        kept_id[i]   = slot_q[(i + 1) % DEPTH];
        kept_live[i] = live_q[(i + 1) % DEPTH];
      end
      dup = dup | (kept_live[i] & (kept_id[i] == raise_id));
    end
  end

  assign full = kept_live[DEPTH-1];
  assign take = raise_vld & ~dup & ~full;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic ins;
      ins = take & ~kept_live[i] & ((i == 0) ? 1'b1 : kept_live[(i + DEPTH - 1) % DEPTH]);
      nxt_id[i]   = ins ? raise_id : kept_id[i];
      nxt_live[i] = kept_live[i] | ins;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
        live_q[g] <= 1'b0;
      end else begin
        slot_q[g] <= nxt_id[g];
        live_q[g] <= nxt_live[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= raise_vld & ~dup & full;
  end

  assign head_vld  = live_q[0];
  assign head_id   = slot_q[0];
  assign offer_vld = head_vld & at_boundary;

endmodule

// File: rtl/pend_irq_queue_chk.sv
module pend_irq_queue_chk #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raise_vld,
  input logic [ID_W-1:0]  raise_id,
  input logic             ack_vld,
  input logic [ID_W-1:0]  ack_id,
  input logic             head_vld,
  input logic [ID_W-1:0]  head_id,
  input logic             overflow,
  input logic [DEPTH-1:0] live_q,
  input logic [ID_W-1:0]  slot_q [DEPTH]
);

  logic ack_hits;
  always_comb begin
    ack_hits = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      ack_hits = ack_hits | (live_q[i] & (slot_q[i] == ack_id));
  end

  AST_LIVE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((live_q + DEPTH'(1)) & live_q) == '0); // R2

  AST_RAISE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_vld && raise_vld && !ack_vld) |=> (head_vld && head_id == $past(raise_id))); // R2

  AST_DUP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && !ack_vld && head_vld && raise_id == head_id) |=> $stable(live_q)); // R3

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($past(raise_vld) && $past(&live_q))); // R4

  AST_ACK_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !raise_vld && head_vld && ack_id == head_id)
      |=> $countones(live_q) == $countones($past(live_q)) - 1); // R5

  AST_ACK_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !raise_vld && !ack_hits) |=> $stable(live_q)); // R6

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && !(ack_vld && ack_id == head_id)) |=> (head_vld && head_id == $past(head_id))); // R8

endmodule

bind pend_irq_queue pend_irq_queue_chk #(.DEPTH(DEPTH), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .raise_id(raise_id),
  .ack_vld(ack_vld), .ack_id(ack_id), .head_vld(head_vld), .head_id(head_id),
  .overflow(overflow), .live_q(live_q), .slot_q(slot_q)
);

// File: tb/pend_irq_queue_tb_top.sv
`timescale 1ns/1ps
module pend_irq_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int ID_W  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic raise_vld, ack_vld, at_boundary;
  logic [ID_W-1:0] raise_id, ack_id;
  logic head_vld, offer_vld, overflow;
  logic [ID_W-1:0] head_id;

  always #4 clk = ~clk;

  pend_irq_queue #(.DEPTH(DEPTH), .ID_W(ID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .raise_id(raise_id),
    .ack_vld(ack_vld), .ack_id(ack_id), .at_boundary(at_boundary),
    .head_vld(head_vld), .head_id(head_id), .offer_vld(offer_vld), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  logic [ID_W-1:0] mq [DEPTH];
  int mn = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit r, input int rid, input bit a, input int aid, input bit b, input string tag);
    bit ovf_e;
    raise_vld = r; raise_id = ID_W'(rid);
    ack_vld = a;   ack_id = ID_W'(aid);
    at_boundary = b;
    @(posedge clk);
    ovf_e = 1'b0;
    if (a) begin
      int k;
      k = -1;
      for (int i = 0; i < mn; i++) if (k < 0 && mq[i] == ID_W'(aid)) k = i;
      if (k >= 0) begin
        for (int j = k; j < mn - 1; j++) mq[j] = mq[j+1];
        mn--;
      end
    end
    if (r) begin
      bit d;
      d = 1'b0;
      for (int i = 0; i < mn; i++) if (mq[i] == ID_W'(rid)) d = 1'b1;
      if (!d) begin
        if (mn == DEPTH) ovf_e = 1'b1;
        else begin mq[mn] = ID_W'(rid); mn++; end
      end
    end
    @(negedge clk);
    chk(tag, "head_vld", int'(head_vld), int'(mn > 0));
    if (mn > 0) chk(tag, "head_id", int'(head_id), int'(mq[0]));
    chk(tag, "offer_vld", int'(offer_vld), int'((mn > 0) && b));
    chk(tag, "overflow", int'(overflow), int'(ovf_e));
  endtask

  task automatic drain(input string tag);
    while (mn > 0) cyc(1'b0, 0, 1'b1, int'(mq[0]), 1'b1, tag);
  endtask

  task automatic fill(input int base, input string tag);
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, base + i, 1'b0, 0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; raise_vld = 1'b0; ack_vld = 1'b0; at_boundary = 1'b1;
    raise_id = '0; ack_id = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "head_vld in reset", int'(head_vld), 0);
    chk("R1", "offer_vld in reset", int'(offer_vld), 0);
    chk("R1", "overflow in reset", int'(overflow), 0);
    rst_n = 1'b1;
    cyc(1'b0, 0, 1'b0, 0, 1'b1, "R1");

    cyc(1'b1, 16'h0101, 1'b0, 0, 1'b1, "R2");
    cyc(1'b1, 16'hbeef, 1'b0, 0, 1'b1, "R2");
    cyc(1'b1, 16'h0007, 1'b0, 0, 1'b0, "R9");
    cyc(1'b0, 0, 1'b0, 0, 1'b1, "R10");
    cyc(1'b0, 0, 1'b0, 0, 1'b1, "R10");
    cyc(1'b1, 16'hbeef, 1'b0, 0, 1'b1, "R3");
    cyc(1'b1, 16'h0101, 1'b0, 0, 1'b1, "R3");
    cyc(1'b0, 0, 1'b1, 16'h5555, 1'b1, "R6");
    cyc(1'b0, 0, 1'b1, 16'hbeef, 1'b1, "R8");
    cyc(1'b1, 16'h0202, 1'b0, 0, 1'b1, "R8");
    drain("R2");

    fill(16'h0100, "R2");
    cyc(1'b1, 16'h0999, 1'b0, 0, 1'b1, "R4");
    cyc(1'b0, 0, 1'b0, 0, 1'b1, "R4");
    cyc(1'b1, 16'h0103, 1'b0, 0, 1'b1, "R3");
    cyc(1'b1, 16'h0999, 1'b1, 16'h0104, 1'b1, "R7");
    cyc(1'b1, 16'h0aaa, 1'b1, 16'h4444, 1'b1, "R4");
    cyc(1'b1, 16'h0100, 1'b1, 16'h0100, 1'b1, "R7");
    drain("R7");

    for (int p = 0; p < DEPTH; p++) begin
      fill(16'h2000 + p * 16, "R5");
      cyc(1'b0, 0, 1'b1, int'(mq[p]), 1'b0, "R5");
      drain("R5");
    end

    lf = 16'hace1;
    for (int n = 0; n < 3000; n++) begin
      bit r, a, b;
      int rid, aid;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r = lf[0] | lf[1];
      a = lf[2] & (lf[5] | lf[6]);
      b = lf[3] | lf[4];
      rid = int'(lf[11:8]) % 12;
      aid = (lf[7] && mn > 0) ? int'(mq[0]) : int'(lf[15:12]) % 12;
      cyc(r, rid, a, aid, b, "R8");
    end
    drain("R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule